// File: doc/BRIEF.md
# Hot-Plug Detect Interrupt Unit

This block watches the hot-plug detect line from a display sink. It brings the line into the local clock domain and removes glitches with a programmable filter. The filtered level is exposed as the connection state. Each rising and each falling transition of that filtered level latches its own event bit.

The block also carries the interrupt line of an external display-controller core. That line is reported live in bit 0 of the status register. All sources drive one interrupt output through an active-high enable mask.

Software sees four word registers:
- address 0: filter configuration;
- address 1: filtered level;
- address 2: interrupt status, cleared by writing ones;
- address 3: interrupt enable.

Reads are combinational on the address. Writes take effect at the next clock edge.

Top module: `hpd_irq_unit`

## Requirements
- R1: The hot-plug input passes through two flip-flops. The filtered level then takes a new value only after the synchronised input has differed from the level on COUNT+1 consecutive sample ticks. The block emits one sample tick every PRESCALE+1 clocks. A pulse shorter than COUNT*(PRESCALE+1) clocks leaves the level unchanged.
- R2: The filter register sits at address 0. PRESCALE occupies bits 15:12 and COUNT occupies bits 7:0. All other bits read as zero. The reset value is 0x0000A0A0.
- R3: A rise of the filtered level sets status bit 1. A fall sets status bit 2. Both bits stay set until software clears them.
- R4: Status bit 0 shows the core interrupt input as a live level. It is not latched.
- R5: A write to address 2 clears every status bit 2:1 whose data bit is 1. Data bits that are 0 leave their status bits unchanged. The write has no effect on bit 0.
- R6: The enable register sits at address 3, bits 2:0, and reads back as written. A 1 in a bit unmasks the source in the same bit position.
- R7: irq_o is high exactly when some status bit and its matching enable bit are both 1.
- R8: Address 1 bit 0 and hpd_level_o both carry the filtered level.
- R9: Reset clears the status bits, the enables and the filtered level, and loads the default filter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hpd_i | input | 1 | Raw hot-plug detect line |
| core_irq_i | input | 1 | Interrupt of the display-controller core |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, combinational on address |
| hpd_level_o | output | 1 | Filtered hot-plug level |
| irq_o | output | 1 | Merged interrupt request |

## Verification
The assertions assume that the write strobe, address and data are stable and known around each rising edge. The clear property also assumes that no filtered edge arrives in the same cycle as a clear, because a new event takes priority over the clear. The bench changes every input half a period away from the clock edge. It issues clears only while the hot-plug line has been quiet for much longer than the filter window, so no event can collide with a clear.

// File: rtl/hpd_irq_pkg.sv
package hpd_irq_pkg;
  localparam int unsigned NSRC     = 3;
  localparam int unsigned SRC_CORE = 0;
  localparam int unsigned SRC_RISE = 1;
  localparam int unsigned SRC_FALL = 2;
  localparam int unsigned PRE_W    = 4;
  localparam int unsigned CNT_W    = 8;
  localparam int unsigned PRE_LSB  = 12;
  localparam int unsigned CNT_LSB  = 0;

  typedef enum logic [1:0] {
    SEL_FILT  = 2'd0,
    SEL_LEVEL = 2'd1,
    SEL_STAT  = 2'd2,
    SEL_MASK  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hpd_glitch_filter.sv
module hpd_glitch_filter #(
  parameter int unsigned PRE_W = 4,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             lvl_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q, prev_q;
  logic             tick;

  assign tick = (pre_q == pre_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;

  // a mismatch must be seen on cnt_i+1 ticks in a row
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (lvl_i == lvl_q) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == cnt_i) begin
        lvl_q <= lvl_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_q;

  assign lvl_o  = lvl_q;
  assign rise_o = lvl_q & ~prev_q;
  assign fall_o = ~lvl_q & prev_q;
endmodule

// File: rtl/hpd_irq_regs.sv
module hpd_irq_regs
  import hpd_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter logic [15:0] FILT_RST = 16'hA0A0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              core_i,
  input  logic              lvl_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PRE_W-1:0]  pre_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [NSRC-1:0]   stat_o,
  output logic [NSRC-1:0]   en_o,
  output logic              irq_o
);
  localparam int unsigned SEL_W = 2;

  logic             hit;
  reg_sel_e         sel;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NSRC-1:0]  en_q;
  logic             rise_q, fall_q;
  logic             wr_filt, wr_stat, wr_mask;

  if (ADDR_W > SEL_W) begin : g_hi
    assign hit = (addr_i[ADDR_W-1:SEL_W] == '0);
  end else begin : g_nohi
    assign hit = 1'b1;
  end
  assign sel = reg_sel_e'(addr_i[SEL_W-1:0]);

  assign wr_filt = we_i && hit && (sel == SEL_FILT);
  assign wr_stat = we_i && hit && (sel == SEL_STAT);
  assign wr_mask = we_i && hit && (sel == SEL_MASK);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pre_q <= FILT_RST[PRE_LSB +: PRE_W];
      cnt_q <= FILT_RST[CNT_LSB +: CNT_W];
    end else if (wr_filt) begin
      pre_q <= wdata_i[PRE_LSB +: PRE_W];
      cnt_q <= wdata_i[CNT_LSB +: CNT_W];
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      en_q <= '0;
    else if (wr_mask) en_q <= wdata_i[NSRC-1:0];

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      if (rise_i)                            rise_q <= 1'b1;
      else if (wr_stat && wdata_i[SRC_RISE]) rise_q <= 1'b0;
      if (fall_i)                            fall_q <= 1'b1;
      else if (wr_stat && wdata_i[SRC_FALL]) fall_q <= 1'b0;
    end

  always_comb begin
    stat_o           = '0;
    stat_o[SRC_CORE] = core_i;
    stat_o[SRC_RISE] = rise_q;
    stat_o[SRC_FALL] = fall_q;
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      unique case (sel)
        SEL_FILT: begin
          rdata_o[PRE_LSB +: PRE_W] = pre_q;
          rdata_o[CNT_LSB +: CNT_W] = cnt_q;
        end
        SEL_LEVEL: rdata_o[0]        = lvl_i;
        SEL_STAT:  rdata_o[NSRC-1:0] = stat_o;
        SEL_MASK:  rdata_o[NSRC-1:0] = en_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign pre_o = pre_q;
  assign cnt_o = cnt_q;
  assign en_o  = en_q;
  assign irq_o = |(stat_o & en_q);
endmodule

// File: rtl/hpd_irq_unit.sv
module hpd_irq_unit
  import hpd_irq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [15:0] FILT_RST    = 16'hA0A0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hpd_i,
  input  logic              core_irq_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              hpd_level_o,
  output logic              irq_o
);
  logic             sync_lvl;
  logic             filt_lvl, rise, fall;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;
  logic [NSRC-1:0]  stat, en;

  hpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (hpd_i),
    .q_o   (sync_lvl)
  );

  hpd_glitch_filter #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sync_lvl),
    .pre_i (pre),
    .cnt_i (cnt),
    .lvl_o (filt_lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  hpd_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILT_RST(FILT_RST)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rise_i (rise),
    .fall_i (fall),
    .core_i (core_irq_i),
    .lvl_i  (filt_lvl),
    .rdata_o(reg_rdata_o),
    .pre_o  (pre),
    .cnt_o  (cnt),
    .stat_o (stat),
    .en_o   (en),
    .irq_o  (irq_o)
  );

  assign hpd_level_o = filt_lvl;
endmodule

// File: rtl/hpd_irq_unit_chk.sv
module hpd_irq_unit_chk
  import hpd_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              sync_lvl,
  input logic              rise,
  input logic [NSRC-1:0]   stat,
  input logic [NSRC-1:0]   en,
  input logic              hpd_level_o,
  input logic              irq_o
);
  logic clr_wr;
  assign clr_wr = reg_we_i && (reg_addr_i == ADDR_W'(2));

  // R1: the level only moves toward the synchronised input
  p_level_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hpd_level_o) |-> hpd_level_o == $past(sync_lvl));

  // R3
  p_rise_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hpd_level_o) |=> stat[SRC_RISE]);

  // R3
  p_fall_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hpd_level_o) |=> stat[SRC_FALL]);

  // R5
  p_clear_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && reg_wdata_i[SRC_RISE] && !rise) |=> !stat[SRC_RISE]);

  // R5
  p_clear_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !reg_wdata_i[SRC_RISE] && stat[SRC_RISE]) |=> stat[SRC_RISE]);

  // R7
  p_masked_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !irq_o);
endmodule

bind hpd_irq_unit hpd_irq_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .sync_lvl   (sync_lvl),
  .rise       (rise),
  .stat       (stat),
  .en         (en),
  .hpd_level_o(hpd_level_o),
  .irq_o      (irq_o)
);

// File: tb/hpd_irq_unit_tb.sv
module hpd_irq_unit_tb;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int NV = 10;
  localparam int P  = 1;
  localparam int C  = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          hpd = 1'b0;
  logic          core = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          lvl, irq;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  hpd_irq_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .hpd_i(hpd), .core_irq_i(core),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .hpd_level_o(lvl), .irq_o(irq)
  );

  // {we, addr[1:0], data[15:0], expected read[15:0]}
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 2'd0, 16'h0000, 16'hA0A0},  // R9 R2 reset filter
    {1'b0, 2'd1, 16'h0000, 16'h0000},  // R9 R8 level
    {1'b0, 2'd2, 16'h0000, 16'h0000},  // R9 status
    {1'b0, 2'd3, 16'h0000, 16'h0000},  // R9 enable
    {1'b1, 2'd0, 16'hFFFF, 16'hF0FF},  // R2 unused bits read zero
    {1'b1, 2'd3, 16'hFFFF, 16'h0007},  // R6
    {1'b1, 2'd3, 16'h0005, 16'h0005},  // R6
    {1'b1, 2'd3, 16'h0000, 16'h0000},  // R6
    {1'b1, 2'd0, 16'h5A21, 16'h5021},  // R2
    {1'b1, 2'd0, 16'h1003, 16'h1003}   // R2 bench setting
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] r;
    wait_n(3);
    rst_ni = 1'b1;
    chk("R9 irq after reset", {31'd0, irq}, 0);
    chk("R9 level after reset", {31'd0, lvl}, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][34]) wr(AW'(VEC[i][33:32]), {16'd0, VEC[i][31:16]});
      rd(AW'(VEC[i][33:32]), r);
      chk($sformatf("R2/R6/R9 vector %0d", i), r, {16'd0, VEC[i][15:0]});
    end

    // R1 glitch shorter than the window
    @(negedge clk) hpd = 1'b1;
    wait_n(C*(P+1) - 1);
    hpd = 1'b0;
    wait_n(30);
    chk("R1 glitch ignored", {31'd0, lvl}, 0);
    rd(2, r);
    chk("R1 glitch sets no event", r, 0);

    // R1 timing window of a real rise
    @(negedge clk) hpd = 1'b1;
    wait_n(2 + C*(P+1) - 1);
    chk("R1 level held inside window", {31'd0, lvl}, 0);
    wait_n(2*(P+1) + 4);
    chk("R1 level changed after window", {31'd0, lvl}, 1);
    rd(1, r);
    chk("R8 level register", r, 1);
    rd(2, r);
    chk("R3 rise latched", r, 32'h2);
    chk("R7 masked rise", {31'd0, irq}, 0);
    wr(3, 32'h2);
    #1 chk("R7 unmasked rise", {31'd0, irq}, 1);
    wr(2, 32'h0);
    rd(2, r);
    chk("R5 zero write keeps", r, 32'h2);
    wr(2, 32'h2);
    rd(2, r);
    chk("R5 one write clears", r, 0);
    chk("R7 irq drops", {31'd0, irq}, 0);

    // fall
    @(negedge clk) hpd = 1'b0;
    wait_n(20);
    chk("R8 level low", {31'd0, lvl}, 0);
    rd(2, r);
    chk("R3 fall latched", r, 32'h4);
    chk("R7 fall masked", {31'd0, irq}, 0);
    wr(3, 32'h4);
    #1 chk("R7 fall unmasked", {31'd0, irq}, 1);
    wr(2, 32'h6);
    rd(2, r);
    chk("R5 clear fall", r, 0);

    // core pass-through
    @(negedge clk) core = 1'b1;
    #1 rd(2, r);
    chk("R4 core live", r, 32'h1);
    chk("R7 core masked", {31'd0, irq}, 0);
    wr(3, 32'h1);
    #1 chk("R7 core unmasked", {31'd0, irq}, 1);
    wr(2, 32'h7);
    rd(2, r);
    chk("R5 clear no effect on bit0", r, 32'h1);
    @(negedge clk) core = 1'b0;
    #1 rd(2, r);
    chk("R4 core not latched", r, 0);
    chk("R7 irq follows core", {31'd0, irq}, 0);

    // reset mid-operation
    wr(3, 32'h7);
    @(negedge clk) hpd = 1'b1;
    wait_n(20);
    rst_ni = 1'b0;
    wait_n(2);
    rd(0, r);
    chk("R9 filter default after reset", r, 32'hA0A0);
    rd(3, r);
    chk("R9 enable cleared", r, 0);
    chk("R9 level cleared", {31'd0, lvl}, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule